// File: doc/BRIEF.md
# Load/Store Address Generator and Load Data Formatter

This block serves the memory stage of a 32-bit load/store pipeline for single-register transfers. From the base register value, an offset that is either an immediate or a second register (shifted or not), an add/subtract choice and an indexing mode, it works out the address that goes to memory. It also works out the new base value and whether that value is written back to the register file. For stores it produces the byte-lane enables that match the access size and the address. For loads it turns the raw memory word into a 32-bit register value. That means picking the byte or halfword lane, extending it with sign or zeros, or rotating a misaligned word.

All outputs are registered and appear one clock after the inputs that produce them. The register file, the bus handshake and the timing of the memory read are outside the block. The low address bits that belong to the returning load word are supplied on their own port (`ld_lane`). The load size and sign are taken from `acc_size` and `acc_signed` in the same cycle as the memory word.

Top module: `ldst_agu_fmt`

## Requirements
- R1: With `use_imm`=1 the offset is `imm_off` zero-extended to 32 bits. With `use_imm`=0 the offset is `offs_reg` after the shifter.
- R2: Shifter encoding of `shift_kind`: 0 shifts left, 1 shifts right logically, 2 shifts right arithmetically, 3 rotates right, each by `shift_amt` (0..31, where 0 means unchanged). Code 4 rotates right by one bit through `carry_in`, with `carry_in` entering bit 31, and ignores `shift_amt`. Codes 5..7 behave as code 0.
- R3: The calculated address is base plus offset when `sub_sel`=0 and base minus offset when `sub_sel`=1, modulo 2^32.
- R4: With `pre_sel`=1 and `wb_en`=0, `mem_addr` is the calculated address and `base_we` is 0.
- R5: With `pre_sel`=1 and `wb_en`=1, `mem_addr` is the calculated address, `base_we` is 1 and `base_next` equals that address.
- R6: With `pre_sel`=0, `mem_addr` equals the unmodified base, `base_we` is 1 whatever `wb_en` is, and `base_next` is the calculated address.
- R7: When `acc_size`=01 (halfword) or `acc_signed`=1, only `imm_off[7:0]` forms the immediate offset, and the register offset is used unshifted. Bits 11:8 and the shift fields have no effect.
- R8: Loads with `acc_size`=00 (byte) take byte lane `ld_lane`. Loads with `acc_size`=01 (halfword) take bits 16*`ld_lane[1]`+15 down to 16*`ld_lane[1]` (little-endian). The value is sign-extended when `acc_signed`=1 and zero-filled otherwise.
- R9: Loads with `acc_size`=10 or 11 (word) return the memory word rotated right by 8*`ld_lane` bits. `acc_signed` has no effect on them.
- R10: For stores (`is_load`=0), `byte_en` (bit i enables byte lane i) uses the low two bits a of `mem_addr`. A byte store gives bit a only, a halfword store gives 0011 when a<2 and 1100 otherwise, and a word store gives 1111. For loads, `byte_en` is 0000.
- R11: Every output changes one clock after its inputs. While `rst_n` is low at a clock edge, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_val | input | 32 | Base register value |
| offs_reg | input | 32 | Offset register value |
| imm_off | input | 12 | Immediate offset |
| use_imm | input | 1 | 1 selects the immediate offset |
| shift_kind | input | 3 | Offset shift mode |
| shift_amt | input | 5 | Offset shift count |
| carry_in | input | 1 | Carry flag for the one-bit rotate through carry |
| sub_sel | input | 1 | 1 subtracts the offset |
| pre_sel | input | 1 | 1 pre-indexed / plain offset, 0 post-indexed |
| wb_en | input | 1 | Writeback request for pre-indexed mode |
| acc_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| acc_signed | input | 1 | Signed load |
| is_load | input | 1 | 1 load, 0 store |
| ld_lane | input | 2 | Low address bits of the returning load word |
| ram_rdata | input | 32 | Raw memory word |
| mem_addr | output | 32 | Address sent to memory |
| byte_en | output | 4 | Store byte-lane enables |
| base_next | output | 32 | Updated base value |
| base_we | output | 1 | Base writeback enable |
| load_result | output | 32 | Formatted load data |

## Verification
The hardest cases to reach are where the shift restriction on narrow accesses interacts with the shifter. A halfword or signed access with a non-zero shift code and a large immediate must ignore both. Only a bench that drives shift fields and upper immediate bits that should have no effect can tell this apart from a design that forgets the restriction. The stimulus therefore uses a base address that reveals any stray upper immediate bit and a shift amount that would change the offset. It then sweeps every shift mode and count with operands that have the top bit both set and clear, so the arithmetic right shift and the rotate through carry are also covered. Loads are swept over every size, sign and lane with words whose selected byte has its top bit both set and clear.

// File: rtl/ldst_pkg.sv
// Shared encodings for the load/store address generator and formatter.
// Assumes a little-endian byte-addressed memory.
package ldst_pkg;
    typedef enum logic [2:0] {
        SH_LSL = 3'd0,
        SH_LSR = 3'd1,
        SH_ASR = 3'd2,
        SH_ROR = 3'd3,
        SH_RRX = 3'd4
    } shift_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORDX = 2'd3
    } acc_size_e;
endpackage

// File: rtl/ldst_offset_shifter.sv
// Offset barrel shifter: shifts or rotates the offset register by an
// immediate count, or rotates it one bit through the carry.
// Assumes shift_amt counts 0..XLEN-1, and 0 leaves the value unchanged.
module ldst_offset_shifter
    import ldst_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]         val_in,
    input  logic [2:0]              kind,
    input  logic [$clog2(XLEN)-1:0] amt,
    input  logic                    cin,
    output logic [XLEN-1:0]         val_out
);
    localparam int SW = $clog2(XLEN);

    logic [SW:0]     rot_back;
    logic [XLEN-1:0] rot_val;

    // Complementary shift distance for the rotate.
    assign rot_back = (SW+1)'(XLEN) - {1'b0, amt};
    assign rot_val  = (val_in >> amt) | (val_in << rot_back);

    // Pick the shift flavour.
    always_comb begin
        case (kind)
            SH_LSR:  val_out = val_in >> amt;
            SH_ASR:  val_out = $signed(val_in) >>> amt;
            SH_ROR:  val_out = rot_val;
            SH_RRX:  val_out = {cin, val_in[XLEN-1:1]};
            default: val_out = val_in << amt;
        endcase
    end
endmodule

// File: rtl/ldst_addr_gen.sv
// Offset selection and address arithmetic. Produces the memory address,
// the updated base value and the writeback enable.
// Assumes pre_sel=1 with wb_en=0 is plain offset mode.
module ldst_addr_gen #(
    parameter int XLEN         = 32,
    parameter int IMM_W        = 12,
    parameter int IMM_NARROW_W = 8
) (
    input  logic [XLEN-1:0]  base,
    input  logic [XLEN-1:0]  raw_reg,
    input  logic [XLEN-1:0]  shifted_reg,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    input  logic             narrow,
    input  logic             sub_sel,
    input  logic             pre_sel,
    input  logic             wb_en,
    output logic [XLEN-1:0]  addr,
    output logic [XLEN-1:0]  base_nxt,
    output logic             base_we
);
    logic [XLEN-1:0] imm_wide;
    logic [XLEN-1:0] imm_short;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] calc;

    assign imm_wide  = XLEN'(imm);
    assign imm_short = XLEN'(imm[IMM_NARROW_W-1:0]);

    // Offset source, with the narrow-access restriction applied.
    always_comb begin
        if (use_imm)
            offset = narrow ? imm_short : imm_wide;
        else
            offset = narrow ? raw_reg : shifted_reg;
    end

    // Add or subtract the offset from the base.
    always_comb begin
        calc = sub_sel ? (base - offset) : (base + offset);
    end

    // Indexing mode: choose the transfer address and writeback.
    always_comb begin
        addr     = pre_sel ? calc : base;
        base_nxt = calc;
        base_we  = ~pre_sel | wb_en;
    end
endmodule

// File: rtl/ldst_store_lanes.sv
// Store byte-lane enable generator. One enable per byte lane, chosen
// from the access size and the low address bits. Zero for loads.
module ldst_store_lanes
    import ldst_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]                    size,
    input  logic                          is_load,
    input  logic [$clog2(XLEN/8)-1:0]     lane,
    output logic [XLEN/8-1:0]             en
);
    localparam int LANES = XLEN / 8;
    localparam int LB    = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic hit;
        // Does this lane belong to the access?
        always_comb begin
            case (size)
                SZ_BYTE: hit = (lane == LB'(i));
                SZ_HALF: hit = (lane[LB-1:1] == (LB-1)'(i >> 1));
                default: hit = 1'b1;
            endcase
        end
        assign en[i] = hit & ~is_load;
    end
endmodule

// File: rtl/ldst_load_format.sv
// Load data formatter. Selects the byte or halfword lane and extends it,
// or rotates a word fetched from a misaligned address.
// Assumes little-endian lanes; a halfword ignores lane bit 0.
module ldst_load_format
    import ldst_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]            rdata,
    input  logic [$clog2(XLEN/8)-1:0]  lane,
    input  logic [1:0]                 size,
    input  logic                       sgn,
    output logic [XLEN-1:0]            result
);
    localparam int LB = $clog2(XLEN / 8);

    logic [2*XLEN-1:0] dbl;
    logic [XLEN-1:0]   rot;
    logic [15:0]       half_v;
    logic [LB:0]       half_base;

    assign dbl       = {rdata, rdata};
    assign rot       = dbl[{lane, 3'b000} +: XLEN];
    assign half_base = {lane[LB-1:1], 1'b0, 1'b0} >> 1;
    assign half_v    = dbl[{half_base, 3'b000} +: 16];

    // Extend the chosen lane, or pass the rotated word.
    always_comb begin
        case (size)
            SZ_BYTE: result = {{(XLEN-8){sgn & rot[7]}}, rot[7:0]};
            SZ_HALF: result = {{(XLEN-16){sgn & half_v[15]}}, half_v};
            default: result = rot;
        endcase
    end
endmodule

// File: rtl/ldst_agu_fmt.sv
// Top of the load/store address generator and load formatter.
// Registers all outputs one cycle after the inputs; synchronous
// active-low reset clears them. Assumes the register file and the bus
// handshake live outside.
module ldst_agu_fmt
    import ldst_pkg::*;
#(
    parameter int XLEN         = 32,
    parameter int IMM_W        = 12,
    parameter int IMM_NARROW_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [XLEN-1:0]             base_val,
    input  logic [XLEN-1:0]             offs_reg,
    input  logic [IMM_W-1:0]            imm_off,
    input  logic                        use_imm,
    input  logic [2:0]                  shift_kind,
    input  logic [$clog2(XLEN)-1:0]     shift_amt,
    input  logic                        carry_in,
    input  logic                        sub_sel,
    input  logic                        pre_sel,
    input  logic                        wb_en,
    input  logic [1:0]                  acc_size,
    input  logic                        acc_signed,
    input  logic                        is_load,
    input  logic [$clog2(XLEN/8)-1:0]   ld_lane,
    input  logic [XLEN-1:0]             ram_rdata,
    output logic [XLEN-1:0]             mem_addr,
    output logic [XLEN/8-1:0]           byte_en,
    output logic [XLEN-1:0]             base_next,
    output logic                        base_we,
    output logic [XLEN-1:0]             load_result
);
    localparam int LANES = XLEN / 8;
    localparam int LB    = $clog2(LANES);

    logic             narrow;
    logic [XLEN-1:0]  shifted;
    logic [XLEN-1:0]  addr_c;
    logic [XLEN-1:0]  base_nxt_c;
    logic             base_we_c;
    logic [LANES-1:0] en_c;
    logic [XLEN-1:0]  ld_c;

    // Halfword or signed accesses use the restricted offset forms.
    assign narrow = (acc_size == SZ_HALF) | acc_signed;

    ldst_offset_shifter #(.XLEN(XLEN)) shifter_i (
        .val_in (offs_reg),
        .kind   (shift_kind),
        .amt    (shift_amt),
        .cin    (carry_in),
        .val_out(shifted)
    );

    ldst_addr_gen #(
        .XLEN(XLEN), .IMM_W(IMM_W), .IMM_NARROW_W(IMM_NARROW_W)
    ) agen_i (
        .base       (base_val),
        .raw_reg    (offs_reg),
        .shifted_reg(shifted),
        .imm        (imm_off),
        .use_imm    (use_imm),
        .narrow     (narrow),
        .sub_sel    (sub_sel),
        .pre_sel    (pre_sel),
        .wb_en      (wb_en),
        .addr       (addr_c),
        .base_nxt   (base_nxt_c),
        .base_we    (base_we_c)
    );

    ldst_store_lanes #(.XLEN(XLEN)) lanes_i (
        .size   (acc_size),
        .is_load(is_load),
        .lane   (addr_c[LB-1:0]),
        .en     (en_c)
    );

    ldst_load_format #(.XLEN(XLEN)) fmt_i (
        .rdata (ram_rdata),
        .lane  (ld_lane),
        .size  (acc_size),
        .sgn   (acc_signed),
        .result(ld_c)
    );

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr    <= '0;
            byte_en     <= '0;
            base_next   <= '0;
            base_we     <= 1'b0;
            load_result <= '0;
        end else begin
            mem_addr    <= addr_c;
            byte_en     <= en_c;
            base_next   <= base_nxt_c;
            base_we     <= base_we_c;
            load_result <= ld_c;
        end
    end

    // R6
    post_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_sel |=> (mem_addr == $past(base_val)) && base_we);

    // R4
    plain_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_sel && !wb_en) |=> !base_we);

    // R10
    load_no_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_load |=> (byte_en == '0));

    // R10
    byte_store_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_load && acc_size == 2'b00) |=> ($countones(byte_en) == 1));

    // R8
    ubyte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_load && acc_size == 2'b00 && !acc_signed) |=> (load_result[XLEN-1:8] == '0));

    // R8
    sbyte_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_load && acc_size == 2'b00 && acc_signed) |=>
        ((load_result[XLEN-1:7] == '0) || (load_result[XLEN-1:7] == '1)));
endmodule

// File: tb/ldst_agu_fmt_tb.sv
`timescale 1ns/1ps
module ldst_agu_fmt_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_val = '0, offs_reg = '0, ram_rdata = '0;
    logic [11:0] imm_off = '0;
    logic        use_imm = 1'b0, carry_in = 1'b0, sub_sel = 1'b0;
    logic        pre_sel = 1'b1, wb_en = 1'b0, acc_signed = 1'b0, is_load = 1'b0;
    logic [2:0]  shift_kind = '0;
    logic [4:0]  shift_amt = '0;
    logic [1:0]  acc_size = 2'd2, ld_lane = '0;
    logic [31:0] mem_addr, base_next, load_result;
    logic [3:0]  byte_en;
    logic        base_we;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ldst_agu_fmt dut_i (
        .clk(clk), .rst_n(rst_n), .base_val(base_val), .offs_reg(offs_reg),
        .imm_off(imm_off), .use_imm(use_imm), .shift_kind(shift_kind),
        .shift_amt(shift_amt), .carry_in(carry_in), .sub_sel(sub_sel),
        .pre_sel(pre_sel), .wb_en(wb_en), .acc_size(acc_size),
        .acc_signed(acc_signed), .is_load(is_load), .ld_lane(ld_lane),
        .ram_rdata(ram_rdata), .mem_addr(mem_addr), .byte_en(byte_en),
        .base_next(base_next), .base_we(base_we), .load_result(load_result)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Inputs are set at a falling edge; results are read one cycle later.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] ref_shift(input logic [31:0] x, input int k,
                                              input int n, input logic c);
        logic [63:0] p;
        logic [32:0] e;
        case (k)
            1: return x / (32'd1 << n);
            2: return x[31] ? ~((~x) / (32'd1 << n)) : x / (32'd1 << n);
            3: begin p = {x, x} / (64'd1 << n); return p[31:0]; end
            4: begin e = {c, x} / 33'd2; return e[31:0]; end
            default: begin p = {32'd0, x} * (64'd1 << n); return p[31:0]; end
        endcase
    endfunction

    function automatic logic [31:0] ref_load(input logic [31:0] w, input int sz,
                                             input bit sg, input int ln);
        logic [63:0] p;
        logic [31:0] v;
        if (sz == 0) begin
            v = (w / (32'd1 << (8*ln))) % 256;
            if (sg && v >= 128) v = v + 32'hFFFF_FF00;
        end else if (sz == 1) begin
            v = (w / (32'd1 << (16*(ln/2)))) % 65536;
            if (sg && v >= 32768) v = v + 32'hFFFF_0000;
        end else begin
            p = {w, w} / (64'd1 << (8*ln));
            v = p[31:0];
        end
        return v;
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h8000_0001; pats[1] = 32'h1234_5678;
        pats[2] = 32'hF0F0_A55A; pats[3] = 32'h7FFF_FFFE;

        // R11: reset clears outputs even with busy inputs.
        base_val = 32'hDEAD_BEEF; offs_reg = 32'h10; wb_en = 1'b1; pre_sel = 1'b0;
        ram_rdata = 32'hFFFF_FFFF;
        @(negedge clk); step(); step();
        chk("R11 reset mem_addr", mem_addr, 32'd0);
        chk("R11 reset base_next", base_next, 32'd0);
        chk("R11 reset base_we", {31'd0, base_we}, 32'd0);
        chk("R11 reset byte_en", {28'd0, byte_en}, 32'd0);
        chk("R11 reset load_result", load_result, 32'd0);
        rst_n = 1'b1;
        pre_sel = 1'b1;

        // R2 and R1: every shift mode and count on the register offset.
        base_val = 32'h4000_0000; acc_size = 2'd2; acc_signed = 1'b0;
        use_imm = 1'b0; sub_sel = 1'b0; wb_en = 1'b1;
        for (int k = 0; k < 6; k++)
            for (int n = 0; n < 32; n++)
                for (int p = 0; p < 4; p++) begin
                    shift_kind = 3'(k); shift_amt = 5'(n);
                    offs_reg = pats[p]; carry_in = p[0];
                    step();
                    chk($sformatf("R2 shift k=%0d n=%0d", k, n), mem_addr,
                        base_val + ref_shift(pats[p], (k == 5) ? 0 : k, n, p[0]));
                end

        // R1: full 12-bit immediate for word accesses.
        use_imm = 1'b1; shift_kind = 3'd1; shift_amt = 5'd3;
        for (int i = 0; i < 4096; i += 273) begin
            imm_off = 12'(i);
            step();
            chk("R1 immediate offset", mem_addr, base_val + 32'(i));
        end

        // R3 R4 R5 R6: add/sub and indexing modes.
        use_imm = 1'b0; shift_kind = 3'd0; shift_amt = 5'd2;
        for (int m = 0; m < 8; m++)
            for (int p = 0; p < 4; p++) begin
                logic [31:0] cal;
                sub_sel = m[0]; pre_sel = m[1]; wb_en = m[2];
                base_val = pats[p] ^ 32'h0000_0100; offs_reg = pats[3 - p];
                cal = m[0] ? base_val - ref_shift(offs_reg, 0, 2, 1'b0)
                           : base_val + ref_shift(offs_reg, 0, 2, 1'b0);
                step();
                chk($sformatf("R3 base_next m=%0d", m), base_next, cal);
                if (m[1]) begin
                    chk("R4 R5 pre address", mem_addr, cal);
                    chk("R4 R5 writeback enable", {31'd0, base_we}, {31'd0, m[2]});
                end else begin
                    chk("R6 post address", mem_addr, base_val);
                    chk("R6 post writeback", {31'd0, base_we}, 32'd1);
                end
            end

        // R7: halfword and signed accesses drop imm[11:8] and the shift.
        pre_sel = 1'b1; wb_en = 1'b0; sub_sel = 1'b0; base_val = 32'h2000_0000;
        for (int c = 0; c < 3; c++) begin
            acc_size = (c == 0) ? 2'd1 : ((c == 1) ? 2'd0 : 2'd2);
            acc_signed = (c != 0);
            use_imm = 1'b1; imm_off = 12'hFAB;
            step();
            chk("R7 narrow immediate", mem_addr, 32'h2000_00AB);
            use_imm = 1'b0; offs_reg = 32'h0000_0321;
            for (int k = 0; k < 5; k++) begin
                shift_kind = 3'(k); shift_amt = 5'd7; carry_in = 1'b1;
                step();
                chk($sformatf("R7 narrow reg unshifted k=%0d", k), mem_addr, 32'h2000_0321);
            end
        end

        // R8 R9: load formatting over sizes, signs, lanes, data.
        is_load = 1'b1; shift_kind = 3'd0; use_imm = 1'b1; imm_off = 12'd1;
        for (int sz = 0; sz < 4; sz++)
            for (int sg = 0; sg < 2; sg++)
                for (int ln = 0; ln < 4; ln++)
                    for (int p = 0; p < 4; p++) begin
                        acc_size = 2'(sz); acc_signed = sg[0]; ld_lane = 2'(ln);
                        ram_rdata = pats[p];
                        step();
                        chk($sformatf("%s load sz=%0d sg=%0d ln=%0d", (sz < 2) ? "R8" : "R9", sz, sg, ln),
                            load_result, ref_load(pats[p], (sz > 2) ? 2 : sz, sg[0], ln));
                        chk("R10 load lanes off", {28'd0, byte_en}, 32'd0);
                    end

        // R10: store byte enables per size and address lane.
        is_load = 1'b0; acc_signed = 1'b0; pre_sel = 1'b1; base_val = 32'h3000_0000;
        for (int sz = 0; sz < 4; sz++)
            for (int a = 0; a < 4; a++) begin
                logic [3:0] ee;
                acc_size = 2'(sz); imm_off = 12'(a + 16);
                ee = (sz == 0) ? 4'(1 << a) : ((sz == 1) ? ((a < 2) ? 4'b0011 : 4'b1100) : 4'b1111);
                step();
                chk($sformatf("R10 store lanes sz=%0d a=%0d", sz, a), {28'd0, byte_en}, {28'd0, ee});
            end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule